// File: doc/BRIEF.md
# Double-Buffered DAC Command Register

This block turns decoded 24-bit command words into the register state of a single-channel voltage DAC. Each command is an 8-bit opcode plus a 16-bit data field. It arrives on a valid/ready stream from the serial front end. The block keeps two registers. A staging (input) register takes new codes. An output (DAC) register holds the code actually presented to the converter. Moving data from staging to output can be done in several ways: by a write-through command, by a flagged software load command, or by an active-low asynchronous load pin. That pin can be pulsed once, or held low to make the staging register transparent.

Reset and the software clear command put the output code at zero or at midscale, as chosen by a level-select pin. The same command stream also sets a power-down flag, a ready-output enable and a linearity-calibration bit. Powering down does not disturb the held code, so leaving power-down restores the earlier output.

The command stream never stalls while out of reset. `cmd_ready` is high whenever `rst_n` is high and low during reset. A command is consumed on every rising clock edge where `cmd_valid` and `cmd_ready` are both high. The upstream side may hold `cmd_valid` high for back-to-back commands, one per cycle.

Top module: `dac_cmd_regfile`

## Requirements
- R1: After a clock edge with `rst_n` low, the staging register is 0. `dac_code` is 0 when `mid_sel` is low and midscale (only the MSB set) when it is high. `pwr_down` is 0, `ready_en` is 1 and `lin_cal` is 0.
- R2: Opcode 0x04 (write) loads the staging register and leaves `dac_code` unchanged while the load pin is inactive.
- R3: Opcode 0x05 (write-through) loads both registers. `dac_code` shows the new code after the accepting edge.
- R4: A low level on `load_n` copies the staging register into the output register. The copy lands on the third rising edge after the pin falls (two synchronizer stages, then the register).
- R5: While `load_n` is held low, any write makes the new staging code appear on `dac_code` after the same accepting edge.
- R6: Opcode 0x01 (software load) copies staging to output when data bit 0 is 1. With data bit 0 at 0 it leaves `dac_code` unchanged.
- R7: Opcode 0x02 (clear) restores every register to the R1 state, using the present `mid_sel`.
- R8: Opcode 0x03 sets `pwr_down` from data bit 0 and `ready_en` from data bit 1. `dac_code` keeps its value through power-down and after power-up.
- R9: Opcode 0x00 and every opcode above 0x06 change no output and no register.
- R10: Opcode 0x06 sets `lin_cal` from data bit 0.
- R11: The code taken from a command is data bits [15:16-CODE_W]. With the default CODE_W of 16 that is the whole data field.
- R12: `cmd_ready` equals `rst_n`. A command takes effect only on an edge where `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mid_sel | input | 1 | Reset/clear level: 0 gives zero, 1 gives midscale |
| load_n | input | 1 | Asynchronous active-low load pin |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_opcode | input | 8 | Command opcode |
| cmd_data | input | 16 | Command data field |
| dac_code | output | CODE_W | Code presented to the converter |
| pwr_down | output | 1 | Power-down flag |
| ready_en | output | 1 | Enable for the chain ready output |
| lin_cal | output | 1 | Linearity calibration bit |

## Verification
The checker watches several rules on every cycle. It checks the reset level, that a plain write leaves the output alone, that write-through lands at once, and that clear, power control and ignored opcodes have their effect on the next cycle. It also checks that the output code holds whenever no command and no load are active, which covers retention through power-down. Only the bench scenarios can show the path through the load-pin synchronizer and transparent mode. The same is true of the flagged software load, which exposes the hidden staging register. Random command mixes against a reference model in the bench cover the interactions between these paths.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  localparam int DATA_W = 16;
  localparam int OP_W   = 8;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 8'h00,
    OP_SWLOAD = 8'h01,
    OP_CLEAR  = 8'h02,
    OP_POWER  = 8'h03,
    OP_WRITE  = 8'h04,
    OP_WTHRU  = 8'h05,
    OP_LIN    = 8'h06
  } op_e;

  // field positions inside the data word
  localparam int FLAG_BIT = 0;
  localparam int PD_BIT   = 0;
  localparam int REN_BIT  = 1;
  localparam int LIN_BIT  = 0;

  typedef struct packed {
    logic stage_wr;   // load staging register from data
    logic out_wr;     // load output register from data
    logic swload;     // flagged staging-to-output copy
    logic clear;      // software clear
    logic power;      // power control
    logic lin;        // linearity bit
  } strobe_t;

endpackage

// File: rtl/dac_load_sync.sv
module dac_load_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], async_n};
  end

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
(
  input  logic            fire,
  input  logic [OP_W-1:0] opcode,
  output strobe_t         strobe
);
  always_comb begin
    strobe = '0;
    if (fire) begin
      case (opcode)
        OP_SWLOAD: strobe.swload = 1'b1;
        OP_CLEAR:  strobe.clear  = 1'b1;
        OP_POWER:  strobe.power  = 1'b1;
        OP_WRITE:  strobe.stage_wr = 1'b1;
        OP_WTHRU: begin
          strobe.stage_wr = 1'b1;
          strobe.out_wr   = 1'b1;
        end
        OP_LIN:    strobe.lin    = 1'b1;
        default:   strobe        = '0;
      endcase
    end
  end
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_cmd_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_sel,
  input  logic              load_low,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] stage_code,
  output logic [CODE_W-1:0] out_code,
  output logic              pd_q,
  output logic              ren_q,
  output logic              lin_q
);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] cmd_code;
  logic [CODE_W-1:0] rst_code;
  logic [CODE_W-1:0] stage_n, out_n;
  logic              pd_n, ren_n, lin_n;

  assign cmd_code = data[DATA_W-1 -: CODE_W];
  assign rst_code = mid_sel ? MID_CODE : '0;

  always_comb begin
    stage_n = stage_code;
    out_n   = out_code;
    pd_n    = pd_q;
    ren_n   = ren_q;
    lin_n   = lin_q;
    if (strobe.clear) begin
      stage_n = '0;
      out_n   = rst_code;
      pd_n    = 1'b0;
      ren_n   = 1'b1;
      lin_n   = 1'b0;
    end else begin
      if (strobe.stage_wr) stage_n = cmd_code;
      if (strobe.out_wr)   out_n   = cmd_code;
      if (strobe.swload && data[FLAG_BIT]) out_n = stage_code;
      if (strobe.power) begin
        pd_n  = data[PD_BIT];
        ren_n = data[REN_BIT];
      end
      if (strobe.lin) lin_n = data[LIN_BIT];
      if (load_low)   out_n = stage_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_code <= '0;
      out_code   <= rst_code;
      pd_q       <= 1'b0;
      ren_q      <= 1'b1;
      lin_q      <= 1'b0;
    end else begin
      stage_code <= stage_n;
      out_code   <= out_n;
      pd_q       <= pd_n;
      ren_q      <= ren_n;
      lin_q      <= lin_n;
    end
  end
endmodule

// File: rtl/dac_cmd_regfile.sv
module dac_cmd_regfile
  import dac_cmd_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_sel,
  input  logic              load_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_opcode,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              ready_en,
  output logic              lin_cal
);
  logic              fire;
  logic              load_sync_n;
  logic              load_low;
  strobe_t           strobe;
  logic [CODE_W-1:0] stage_code;

  assign cmd_ready = rst_n;
  assign fire      = cmd_valid & cmd_ready;

  dac_load_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (load_n),
    .sync_n  (load_sync_n)
  );
  assign load_low = ~load_sync_n;

  dac_cmd_decode u_dec (
    .fire   (fire),
    .opcode (cmd_opcode),
    .strobe (strobe)
  );

  dac_reg_bank #(.CODE_W(CODE_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .mid_sel    (mid_sel),
    .load_low   (load_low),
    .strobe     (strobe),
    .data       (cmd_data),
    .stage_code (stage_code),
    .out_code   (dac_code),
    .pd_q       (pwr_down),
    .ren_q      (ren_q_w),
    .lin_q      (lin_cal)
  );

  logic ren_q_w;
  assign ready_en = ren_q_w;
endmodule

// File: rtl/dac_cmd_regfile_chk.sv
module dac_cmd_regfile_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mid_sel,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_opcode,
  input logic [15:0]       cmd_data,
  input logic [CODE_W-1:0] dac_code,
  input logic              pwr_down,
  input logic              ready_en,
  input logic              lin_cal,
  input logic              load_low
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  p_reset_level_r1: assert property (@(posedge clk)
    !rst_n |=> (dac_code == ($past(mid_sel) ? MID : '0)) && !pwr_down && ready_en && !lin_cal);

  p_write_holds_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_opcode == 8'h04 && !load_low |=> $stable(dac_code));

  p_wthru_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_opcode == 8'h05 |=> dac_code == $past(cmd_data[15 -: CODE_W]));

  p_clear_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_opcode == 8'h02 |=>
      (dac_code == ($past(mid_sel) ? MID : '0)) && !pwr_down && ready_en && !lin_cal);

  p_power_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_opcode == 8'h03 |=>
      pwr_down == $past(cmd_data[0]) && ready_en == $past(cmd_data[1]));

  p_code_retained_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire && !load_low |=> $stable(dac_code));

  p_ignored_ops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (cmd_opcode == 8'h00 || cmd_opcode > 8'h06) && !load_low |=>
      $stable(dac_code) && $stable(pwr_down) && $stable(ready_en) && $stable(lin_cal));

  p_lin_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_opcode == 8'h06 |=> lin_cal == $past(cmd_data[0]));

  p_ready_follows_reset_r12: assert property (@(posedge clk)
    cmd_ready == rst_n);
endmodule

bind dac_cmd_regfile dac_cmd_regfile_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mid_sel    (mid_sel),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_opcode (cmd_opcode),
  .cmd_data   (cmd_data),
  .dac_code   (dac_code),
  .pwr_down   (pwr_down),
  .ready_en   (ready_en),
  .lin_cal    (lin_cal),
  .load_low   (load_low)
);

// File: tb/dac_cmd_regfile_test.sv
module dac_cmd_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 16;
  localparam logic [15:0] MID = 16'h8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mid_sel = 1'b0;
  logic        load_n = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode = 8'h00;
  logic [15:0] cmd_data = 16'h0000;
  logic [15:0] dac_code;
  logic        pwr_down, ready_en, lin_cal;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] m_stage, m_out;
  logic        m_pd, m_ren, m_lin, m_transp;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_regfile #(.CODE_W(CODE_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .load_n(load_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_data(cmd_data), .dac_code(dac_code), .pwr_down(pwr_down),
    .ready_en(ready_en), .lin_cal(lin_cal)
  );

  function automatic logic [15:0] level_code(input logic sel);
    return sel ? MID : 16'h0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check(req, 32'(dac_code), 32'(m_out));
    check(req, 32'(pwr_down), 32'(m_pd));
    check(req, 32'(ready_en), 32'(m_ren));
    check(req, 32'(lin_cal), 32'(m_lin));
  endtask

  task automatic model_reset();
    m_stage = 16'h0; m_out = level_code(mid_sel);
    m_pd = 1'b0; m_ren = 1'b1; m_lin = 1'b0;
  endtask

  task automatic model_cmd(input logic [7:0] op, input logic [15:0] d);
    if (op == 8'h02) begin
      model_reset();
    end else begin
      case (op)
        8'h01: if (d[0]) m_out = m_stage;
        8'h03: begin m_pd = d[0]; m_ren = d[1]; end
        8'h04: m_stage = d;
        8'h05: begin m_stage = d; m_out = d; end
        8'h06: m_lin = d[0];
        default: ;
      endcase
      if (m_transp) m_out = m_stage;
    end
  endtask

  // drive at negedge, effect at next posedge, sample at following negedge
  task automatic send(input logic [7:0] op, input logic [15:0] d, input string req);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_cmd(op, d);
    check_all(req);
  endtask

  task automatic do_reset(input logic sel);
    mid_sel = sel; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12", 32'(cmd_ready), 32'd0);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check_all("R1");
    check("R12", 32'(cmd_ready), 32'd1);
  endtask

  initial begin
    m_transp = 1'b0;
    model_reset();
    @(negedge clk);
    do_reset(1'b0);
    // R1 staging cleared: software load shows zero
    send(8'h01, 16'h0001, "R1");

    do_reset(1'b1);
    send(8'h04, 16'h1234, "R2");
    send(8'h01, 16'h0000, "R6");
    send(8'h01, 16'h0001, "R6");
    send(8'h05, 16'hBEEF, "R3");
    send(8'h05, 16'hA5C3, "R11");

    // valid low: no effect
    cmd_opcode = 8'h05; cmd_data = 16'h0F0F;
    @(negedge clk);
    check("R12", 32'(dac_code), 32'(m_out));

    // power down retains code
    send(8'h03, 16'h0001, "R8");
    repeat (3) @(negedge clk);
    check("R8", 32'(dac_code), 32'(m_out));
    send(8'h03, 16'h0002, "R8");
    send(8'h03, 16'h0003, "R8");
    send(8'h03, 16'h0002, "R8");

    send(8'h06, 16'h0001, "R10");
    send(8'h06, 16'h0000, "R10");

    send(8'h00, 16'hFFFF, "R9");
    send(8'h07, 16'hFFFF, "R9");
    send(8'hFF, 16'h0001, "R9");
    send(8'h01, 16'h0001, "R9");

    // load pin pulse: staging written, then copy lands on third edge
    send(8'h04, 16'h4321, "R4");
    load_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R4", 32'(dac_code), 32'(m_out));
    @(negedge clk);
    check("R4", 32'(dac_code), 32'h4321);
    load_n = 1'b1;
    m_out = 16'h4321;
    repeat (3) @(negedge clk);

    // held low: transparent
    load_n = 1'b0;
    repeat (3) @(negedge clk);
    m_transp = 1'b1;
    send(8'h04, 16'h7777, "R5");
    send(8'h04, 16'h0101, "R5");
    load_n = 1'b1;
    repeat (3) @(negedge clk);
    m_transp = 1'b0;

    // clear with both levels
    mid_sel = 1'b0;
    send(8'h02, 16'hFFFF, "R7");
    send(8'h01, 16'h0001, "R7");
    send(8'h05, 16'h5555, "R7");
    mid_sel = 1'b1;
    send(8'h02, 16'h0000, "R7");

    // constrained random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      logic [15:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      op = (sel < 7) ? 8'(sel) : ((sel == 7) ? 8'h07 : 8'(8'h10 + $urandom_range(0, 200)));
      d = 16'($urandom);
      if ($urandom_range(0, 15) == 0) mid_sel = ~mid_sel;
      send(op, d, "R9");
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule